// File: doc/BRIEF.md
# Framed Streaming Histogram Accumulator

This block builds the histogram of a frame of 256 six-bit unsigned samples. A sample is counted on every rising clock edge where the input valid strobe is high and reset is low. There is no ready signal, so the block accepts one sample per cycle without stalling. That includes long runs of one value on consecutive cycles. Cycles with the strobe low may fall anywhere inside a frame, and they do not advance the frame.

The cycle after the 256th sample is accepted, the block starts streaming its 64 bin counts. It sends one bin per cycle in ascending bin order with no gaps. Each count is presented as a 16-bit unsigned value. Each bin register is cleared as it is read, so the next frame starts from an empty histogram with no separate clear pass. A synchronous reset drops a partly collected frame and stops any readout in progress.

Top module: `frame_histogram`

## Requirements
- R1: A sample is counted only on an edge where in_valid is 1 and rst is 0. Cycles with in_valid at 0 do not advance the frame, so out_valid stays 0 until the 256th accepted sample.
- R2: If the 256th accepted sample lands on cycle N, then on cycle N+1 out_valid is 1 and bin_index is 0.
- R3: While out_valid is 1, bin_index goes up by exactly one each cycle, from 0 to 63, with no gaps. On the cycle after bin 63, out_valid is 0.
- R4: The bin_count shown with bin_index k is the number of accepted samples of value k in the finished frame, zero-extended to 16 bits. This holds for any value pattern, including 256 identical samples on consecutive cycles (count 256), and it includes the 256th sample.
- R5: The 64 counts reported for one frame add up to exactly 256.
- R6: Whenever out_valid is 0, both bin_index and bin_count are 0.
- R7: No count carries over into the next frame. A frame that starts on the cycle right after the readout of bin 63 starts from an all-zero histogram.
- R8: rst is synchronous and active-high. While it is 1, the outputs are all 0. It discards a partial frame and cancels a readout in progress. A cycle with rst at 1 counts no sample, and the first sample accepted after it opens a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample strobe; sample_in is counted when high |
| sample_in | input | 6 | Unsigned sample value 0 to 63 |
| out_valid | output | 1 | High while a bin is being reported |
| bin_index | output | 6 | Number of the bin being reported |
| bin_count | output | 16 | Count of the reported bin |

## Verification
The hardest cases to reach from the ports combine a register update and a read in the same cycle. One is a 256th sample that falls in bin 0, which is read on the very next cycle. The other is a new frame starting on the cycle right after bin 63, while the registers that were just read must already be zero. The stimulus covers both directly. It runs frames made entirely of value 0 and entirely of one other value, and it chains random frames back to back with no idle cycle between the end of a readout and the first new sample. A reset in the middle of a frame and another in the middle of a readout (with in_valid held high during the reset cycle) show that no stale count survives. Random idle gaps inside frames check that the readout still starts exactly one cycle after the last accepted sample.

// File: rtl/hist_pkg.sv
package hist_pkg;

    localparam int unsigned SAMPLE_W_DEF  = 6;
    localparam int unsigned FRAME_LEN_DEF = 256;
    localparam int unsigned COUNT_W_DEF   = 16;

    typedef enum logic {
        PH_COLLECT = 1'b0,
        PH_READ    = 1'b1
    } hist_phase_e;

endpackage

// File: rtl/hist_frame_ctrl.sv
module hist_frame_ctrl
    import hist_pkg::*;
#(
    parameter int unsigned SAMPLE_W  = SAMPLE_W_DEF,
    parameter int unsigned FRAME_LEN = FRAME_LEN_DEF
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    output logic                accept,
    output logic                reading,
    output logic [SAMPLE_W-1:0] rd_ptr
);

    localparam int unsigned NUM_BINS = 1 << SAMPLE_W;
    localparam int unsigned FCNT_W   = $clog2(FRAME_LEN);
    localparam logic [FCNT_W-1:0]   LAST_SAMPLE = FCNT_W'(FRAME_LEN - 1);
    localparam logic [SAMPLE_W-1:0] LAST_BIN    = SAMPLE_W'(NUM_BINS - 1);

    typedef struct packed {
        hist_phase_e         phase;
        logic [FCNT_W-1:0]   fcnt;
        logic [SAMPLE_W-1:0] rptr;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;
    logic  accept_d;

    always_comb begin
        ctrl_d   = ctrl_q;
        accept_d = in_valid && (ctrl_q.phase == PH_COLLECT);
        if (ctrl_q.phase == PH_COLLECT) begin
            if (accept_d) begin
                if (ctrl_q.fcnt == LAST_SAMPLE) begin
                    ctrl_d.phase = PH_READ;
                    ctrl_d.fcnt  = '0;
                    ctrl_d.rptr  = '0;
                end else begin
                    ctrl_d.fcnt = ctrl_q.fcnt + 1'b1;
                end
            end
        end else begin
            ctrl_d.rptr = ctrl_q.rptr + 1'b1;
            if (ctrl_q.rptr == LAST_BIN) begin
                ctrl_d.phase = PH_COLLECT;
                ctrl_d.rptr  = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '{phase: PH_COLLECT, fcnt: '0, rptr: '0};
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign accept  = accept_d;
    assign reading = (ctrl_q.phase == PH_READ);
    assign rd_ptr  = ctrl_q.rptr;

    AST_IDLE_HOLDS_COUNT: assert property (@(posedge clk) disable iff (rst)
        (!in_valid && !reading) |=> $stable(ctrl_q.fcnt)); // R1
    AST_LAST_OPENS_READ: assert property (@(posedge clk) disable iff (rst)
        (accept && ctrl_q.fcnt == LAST_SAMPLE) |=> (reading && rd_ptr == '0)); // R2

endmodule

// File: rtl/hist_bin_bank.sv
module hist_bin_bank
    import hist_pkg::*;
#(
    parameter int unsigned SAMPLE_W  = SAMPLE_W_DEF,
    parameter int unsigned FRAME_LEN = FRAME_LEN_DEF
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic                                   inc_en,
    input  logic [SAMPLE_W-1:0]                    inc_sel,
    input  logic                                   clr_en,
    input  logic [SAMPLE_W-1:0]                    clr_sel,
    output logic [(1<<SAMPLE_W)*$clog2(FRAME_LEN+1)-1:0] bins_flat
);

    localparam int unsigned NUM_BINS = 1 << SAMPLE_W;
    localparam int unsigned CNT_W    = $clog2(FRAME_LEN + 1);

    for (genvar k = 0; k < NUM_BINS; k++) begin : g_bin
        localparam logic [SAMPLE_W-1:0] IDX = SAMPLE_W'(k);
        logic [CNT_W-1:0] cnt_d, cnt_q;

        always_comb begin
            cnt_d = cnt_q;
            if (clr_en && clr_sel == IDX) begin
                cnt_d = '0;
            end else if (inc_en && inc_sel == IDX) begin
                cnt_d = cnt_q + 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_d;
            end
        end

        assign bins_flat[k*CNT_W +: CNT_W] = cnt_q;

        AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
            cnt_q <= CNT_W'(FRAME_LEN)); // R4
        AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (rst)
            (clr_en && clr_sel == IDX) |=> (cnt_q == '0)); // R7
    end

endmodule

// File: rtl/hist_read_mux.sv
module hist_read_mux
    import hist_pkg::*;
#(
    parameter int unsigned SAMPLE_W  = SAMPLE_W_DEF,
    parameter int unsigned FRAME_LEN = FRAME_LEN_DEF,
    parameter int unsigned COUNT_W   = COUNT_W_DEF
) (
    input  logic                                   reading,
    input  logic [SAMPLE_W-1:0]                    rd_ptr,
    input  logic [(1<<SAMPLE_W)*$clog2(FRAME_LEN+1)-1:0] bins_flat,
    output logic                                   out_valid,
    output logic [SAMPLE_W-1:0]                    bin_index,
    output logic [COUNT_W-1:0]                     bin_count
);

    localparam int unsigned CNT_W = $clog2(FRAME_LEN + 1);

    logic [CNT_W-1:0] picked;

    always_comb begin
        picked    = bins_flat[int'(rd_ptr)*CNT_W +: CNT_W];
        out_valid = reading;
        bin_index = reading ? rd_ptr : '0;
        bin_count = reading ? COUNT_W'(picked) : '0;
    end

endmodule

// File: rtl/frame_histogram.sv
module frame_histogram
    import hist_pkg::*;
#(
    parameter int unsigned SAMPLE_W  = SAMPLE_W_DEF,
    parameter int unsigned FRAME_LEN = FRAME_LEN_DEF,
    parameter int unsigned COUNT_W   = COUNT_W_DEF
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] sample_in,
    output logic                out_valid,
    output logic [SAMPLE_W-1:0] bin_index,
    output logic [COUNT_W-1:0]  bin_count
);

    localparam int unsigned NUM_BINS = 1 << SAMPLE_W;
    localparam int unsigned CNT_W    = $clog2(FRAME_LEN + 1);
    localparam logic [SAMPLE_W-1:0] LAST_BIN = SAMPLE_W'(NUM_BINS - 1);

    logic                      accept;
    logic                      reading;
    logic [SAMPLE_W-1:0]       rd_ptr;
    logic [NUM_BINS*CNT_W-1:0] bins_flat;

    hist_frame_ctrl #(.SAMPLE_W(SAMPLE_W), .FRAME_LEN(FRAME_LEN)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .accept   (accept),
        .reading  (reading),
        .rd_ptr   (rd_ptr)
    );

    hist_bin_bank #(.SAMPLE_W(SAMPLE_W), .FRAME_LEN(FRAME_LEN)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .inc_en    (accept),
        .inc_sel   (sample_in),
        .clr_en    (reading),
        .clr_sel   (rd_ptr),
        .bins_flat (bins_flat)
    );

    hist_read_mux #(.SAMPLE_W(SAMPLE_W), .FRAME_LEN(FRAME_LEN), .COUNT_W(COUNT_W)) u_mux (
        .reading   (reading),
        .rd_ptr    (rd_ptr),
        .bins_flat (bins_flat),
        .out_valid (out_valid),
        .bin_index (bin_index),
        .bin_count (bin_count)
    );

    AST_START_AT_BIN0: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> (bin_index == '0)); // R2
    AST_BIN_STEP: assert property (@(posedge clk) disable iff (rst)
        (out_valid && bin_index != LAST_BIN) |=>
            (out_valid && bin_index == SAMPLE_W'($past(bin_index) + 1'b1))); // R3
    AST_READ_END: assert property (@(posedge clk) disable iff (rst)
        (out_valid && bin_index == LAST_BIN) |=> !out_valid); // R3
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (bin_index == '0 && bin_count == '0)); // R6
    AST_RESET_CANCEL: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !out_valid); // R8

endmodule

// File: tb/frame_histogram_test.sv
`timescale 1ns/1ps
module frame_histogram_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [5:0]  sample_in = '0;
    logic        out_valid;
    logic [5:0]  bin_index;
    logic [15:0] bin_count;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    int exp_bins [64];

    always #5 clk = ~clk;

    frame_histogram uut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .sample_in (sample_in),
        .out_valid (out_valid),
        .bin_index (bin_index),
        .bin_count (bin_count)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, expv, $time);
        end
    endtask

    function automatic logic [5:0] pick(input int mode, input int i);
        case (mode)
            0: return 6'd37;
            1: return 6'd0;
            2: return 6'(i);
            3: return 6'($urandom_range(63));
            default: return ($urandom_range(9) < 7) ? 6'($urandom_range(3)) : 6'd63;
        endcase
    endfunction

    task automatic clear_model();
        for (int b = 0; b < 64; b++) exp_bins[b] = 0;
    endtask

    // drive one cycle; outputs must be idle while collecting (R6)
    task automatic push(input bit v, input logic [5:0] val, input string req);
        @(negedge clk);
        chk(out_valid == 1'b0, req, int'(out_valid), 0);
        chk(bin_index == '0 && bin_count == '0, "R6", int'(bin_count), 0);
        in_valid  = v;
        sample_in = val;
        if (v) exp_bins[val]++;
    endtask

    task automatic feed(input int mode, input int idle_pct, input int n);
        for (int i = 0; i < n; i++) begin
            while ($urandom_range(99) < idle_pct) push(1'b0, 6'($urandom_range(63)), "R1");
            push(1'b1, pick(mode, i), "R6");
        end
    endtask

    task automatic readout(input string tag, input int n_bins, input bit tail);
        int sum = 0;
        for (int b = 0; b < n_bins; b++) begin
            @(negedge clk);
            in_valid = 1'b0;
            if (b == 0) chk(out_valid == 1'b1 && bin_index == 6'd0, "R2", int'(out_valid), 1);
            else chk(out_valid == 1'b1 && bin_index == 6'(b), "R3", int'(bin_index), b);
            chk(int'(bin_count) == exp_bins[b], tag, int'(bin_count), exp_bins[b]);
            sum += int'(bin_count);
        end
        if (n_bins == 64) begin
            chk(sum == 256, "R5", sum, 256);
            clear_model();
        end
        if (tail) begin
            @(negedge clk);
            chk(out_valid == 1'b0 && bin_index == '0 && bin_count == '0, "R3", int'(out_valid), 0);
        end
    endtask

    task automatic do_reset(input bit v_during);
        @(negedge clk);
        rst = 1'b1;
        in_valid = v_during;
        sample_in = 6'd5;
        @(negedge clk);
        chk(out_valid == 1'b0 && bin_index == '0 && bin_count == '0, "R8", int'(out_valid), 0);
        rst = 1'b0;
        in_valid = 1'b0;
        clear_model();
    endtask

    initial begin
        repeat (2000000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        clear_model();
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0 && bin_index == '0 && bin_count == '0, "R8", int'(out_valid), 0);
        rst = 1'b0;

        // R4: one value on 256 consecutive cycles
        feed(0, 0, 256);
        readout("R4", 64, 1'b1);
        // R4: all zeros, last sample lands in the bin read first
        feed(1, 0, 256);
        readout("R4", 64, 1'b1);
        // R4: uniform, four per bin
        feed(2, 0, 256);
        readout("R4", 64, 1'b1);

        // R1: 255 samples, long idle, no readout may start
        feed(3, 30, 255);
        for (int i = 0; i < 40; i++) push(1'b0, 6'd9, "R1");
        push(1'b1, 6'd0, "R1");
        readout("R1", 64, 1'b1);

        // R7: back-to-back random frames, next frame right after bin 63
        for (int f = 0; f < 6; f++) begin
            feed((f % 2) ? 4 : 3, (f < 3) ? 0 : 20, 256);
            readout("R7", 64, 1'b0);
        end

        // R8: reset mid-frame, valid held high during reset
        feed(3, 10, 100);
        do_reset(1'b1);
        feed(3, 10, 256);
        readout("R8", 64, 1'b1);

        // R8: reset mid-readout, then fresh frame must be clean
        feed(0, 0, 256);
        readout("R4", 10, 1'b0);
        do_reset(1'b1);
        chk(out_valid == 1'b0, "R8", int'(out_valid), 0);
        feed(4, 5, 256);
        readout("R8", 64, 1'b1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule